// File: doc/BRIEF.md
# I2C Channel-Select Register Target

This block is the digital core of a four-way I2C bus switch. It listens to the upstream SCL and SDA lines, which are oversampled on a fast system clock, and answers one 7-bit target address. The upper four bits of that address are fixed and the lower three come from strap inputs. A write stores a one-byte channel selection. A read returns that selection together with the live interrupt state of the four downstream segments.

The selection does not reach the switch enables as soon as the data byte is acknowledged. It is held pending and drives the one-hot channel enables only on the next stop condition, so that every downstream segment is idle when it connects. SDA is driven as an open-drain pull: a high output means the line is pulled low.

Top module: `i2c_chan_select_slave`

## Requirements
- R1: After reset, `chan_en_o` is 0, `sda_pull_o` is 0, and a read of the register returns 0 in bits 3..0.
- R2: The block responds only to the address {1110, `addr_strap_i[2:0]`}. For any other address it leaves SDA released in the ninth clock, and it ignores the rest of that transfer.
- R3: The last bit of the address byte selects the direction: 0 is a write and 1 is a read. On a matching address the block pulls SDA low for the ninth clock. During a write it also acknowledges every data byte in the same way.
- R4: When several data bytes arrive in one write, only the last complete byte is kept.
- R5: Register bit 2 is the enable. When it is 0, no channel is on. When it is 1, bits 1..0 give the channel number n, and `chan_en_o` equals 1 << n. At most one enable is ever high.
- R6: `chan_en_o` holds its old value through the data ACK. It takes the new selection on the stop condition that ends the write, a few system clocks after SDA rises.
- R7: Read data is {flags[3:0], 0, stored bits 2..0}. Flag n is 1 when `irq_ni[n]` is 0. The flags are sampled when the byte is loaded for sending.
- R8: In a read, a master ACK causes the register byte to be sent again. A master NACK makes the block release SDA, which then stays released until the next start.
- R9: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Pulses on SCL or SDA shorter than `FILT_CYC` system clocks are ignored.
- R10: A start or stop that arrives before the eighth bit of a byte aborts that byte and leaves the register unchanged.
- R11: Written bits 7..3 are ignored. Bit 3 always reads as 0, and bits 7..4 always show the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16 times the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Upstream SCL level |
| sda_i | input | 1 | Upstream SDA level (wired bus value) |
| addr_strap_i | input | 3 | Low three address bits from straps |
| irq_ni | input | 4 | Downstream interrupt lines, active low |
| sda_pull_o | output | 1 | 1 pulls upstream SDA low |
| chan_en_o | output | 4 | One-hot downstream channel enables |

## Verification
Two functions can act on the same stop condition: it activates a selection that was held pending, and it aborts a half-received byte that follows it. The bench provokes this by writing a full selection byte, clocking only three bits of a second byte, and then issuing a stop. The result is judged correct if the enables take the first byte's channel and a read-back returns the first byte, with no part of the truncated one.

// File: rtl/i2c_chsel_pkg.sv
package i2c_chsel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;

  localparam logic [3:0] ADDR_FIXED = 4'b1110;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned FILT_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != out_q) begin
        // accept only after FILT_CYC consecutive differing samples
        if (cnt_q == CW'(FILT_CYC - 1)) begin
          out_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_f_i;
      sda_d_q <= sda_f_i;
    end
  end

  assign scl_rise_o = scl_f_i & ~scl_d_q;
  assign scl_fall_o = ~scl_f_i & scl_d_q;
  assign start_o    = scl_f_i & scl_d_q & sda_d_q & ~sda_f_i;
  assign stop_o     = scl_f_i & scl_d_q & ~sda_d_q & sda_f_i;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_chsel_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sda_f_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] rd_byte_i,
  output logic       sda_pull_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_byte_o,
  output tgt_state_e state_o
);
  tgt_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q;
  logic       pull_q, rw_q, mack_q, wr_stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      pull_q   <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      wr_stb_q <= 1'b0;
    end else begin
      wr_stb_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_f_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (sh_q[7:1] == dev_addr_i) begin
                pull_q  <= 1'b1;
                rw_q    <= sh_q[0];
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q    <= rd_byte_i;
                pull_q  <= ~rd_byte_i[7];
                state_q <= ST_RD;
              end else begin
                pull_q  <= 1'b0;
                state_q <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_f_i};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == 4'd7) wr_stb_q <= 1'b1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              pull_q  <= 1'b1;
              state_q <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              pull_q  <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall_i) begin
              if (cnt_q == 4'd7) begin
                pull_q  <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                sh_q   <= {sh_q[6:0], 1'b0};
                pull_q <= ~sh_q[6];
                cnt_q  <= cnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_f_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                sh_q    <= rd_byte_i;
                pull_q  <= ~rd_byte_i[7];
                cnt_q   <= '0;
                state_q <= ST_RD;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_stb_o   = wr_stb_q;
  assign wr_byte_o  = sh_q;
  assign state_o    = state_q;
endmodule

// File: rtl/i2c_chan_select_slave.sv
module i2c_chan_select_slave
  import i2c_chsel_pkg::*;
#(
  parameter int unsigned FILT_CYC = 3,
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned STRAP_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] addr_strap_i,
  input  logic [NUM_CH-1:0]  irq_ni,
  output logic               sda_pull_o,
  output logic [NUM_CH-1:0]  chan_en_o
);
  localparam int unsigned SEL_W = $clog2(NUM_CH);
  localparam int unsigned REG_W = SEL_W + 1;
  localparam int unsigned PAD_W = 8 - NUM_CH - REG_W;

  logic [1:0] raw_lines, filt_lines;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic       wr_stb;
  logic [7:0] wr_byte, rd_byte;
  tgt_state_e fsm_state;

  assign raw_lines = {sda_i, scl_i};

  for (genvar l = 0; l < 2; l++) begin : g_filt
    i2c_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[l]),
      .line_o(filt_lines[l])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  i2c_bus_events u_ev (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_f_i   (scl_f),
    .sda_f_i   (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_target_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .sda_f_i   (sda_f),
    .dev_addr_i({ADDR_FIXED, addr_strap_i}),
    .rd_byte_i (rd_byte),
    .sda_pull_o(sda_pull_o),
    .wr_stb_o  (wr_stb),
    .wr_byte_o (wr_byte),
    .state_o   (fsm_state)
  );

  // interrupt inputs: two-stage sync, idle high
  logic [NUM_CH-1:0] irq_s1_q, irq_s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_s1_q <= '1;
      irq_s2_q <= '1;
    end else begin
      irq_s1_q <= irq_ni;
      irq_s2_q <= irq_s1_q;
    end
  end

  logic [REG_W-1:0]  ctrl_q;
  logic              pend_q;
  logic [NUM_CH-1:0] en_q, en_dec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign en_dec[c] = ctrl_q[SEL_W] && (ctrl_q[SEL_W-1:0] == SEL_W'(c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      en_q   <= '0;
    end else if (wr_stb) begin
      ctrl_q <= wr_byte[REG_W-1:0];
      pend_q <= 1'b1;
    end else if (stop_det && pend_q) begin
      en_q   <= en_dec;
      pend_q <= 1'b0;
    end
  end

  assign rd_byte   = {~irq_s2_q, {PAD_W{1'b0}}, ctrl_q};
  assign chan_en_o = en_q;
endmodule

// File: rtl/i2c_chan_select_chk.sv
module i2c_chan_select_chk
  import i2c_chsel_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_CH-1:0]         chan_en_i,
  input logic                      sda_pull_i,
  input logic                      scl_f_i,
  input logic                      stop_i,
  input logic                      pend_i,
  input logic [$clog2(NUM_CH):0]   ctrl_i,
  input tgt_state_e                state_i
);
  localparam int unsigned SEL_W = $clog2(NUM_CH);

  AST_EN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_en_i)); // R5

  AST_EN_ONLY_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_en_i) |-> $past(stop_i)); // R6

  AST_EN_FOLLOWS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && pend_i && ctrl_i[SEL_W] |=>
      chan_en_i == (NUM_CH'(1) << $past(ctrl_i[SEL_W-1:0]))); // R5

  AST_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && pend_i && !ctrl_i[SEL_W] |=> chan_en_i == '0); // R5

  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !pend_i); // R6

  AST_PULL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_i) |-> !$past(scl_f_i)); // R3

  AST_PULL_ADDRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_i |-> state_i != ST_IDLE); // R2
endmodule

bind i2c_chan_select_slave i2c_chan_select_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chan_en_i (chan_en_o),
  .sda_pull_i(sda_pull_o),
  .scl_f_i   (scl_f),
  .stop_i    (stop_det),
  .pend_i    (pend_q),
  .ctrl_i    (ctrl_q),
  .state_i   (fsm_state)
);

// File: tb/sim_i2c_chan_select_slave.sv
module sim_i2c_chan_select_slave;
  localparam int Q = 20;
  localparam logic [7:0] WR_ADDR = 8'hEA;  // 1110_101_0
  localparam logic [7:0] RD_ADDR = 8'hEB;
  localparam logic [7:0] BAD_WR  = 8'hE4;  // strap 010

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [3:0] irq_n = 4'hF;
  logic sda_pull;
  logic [3:0] chan_en;
  logic sda_bus;

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  i2c_chan_select_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_strap_i(3'b101), .irq_ni(irq_n),
    .sda_pull_o(sda_pull), .chan_en_o(chan_en)
  );

  typedef struct { string req; logic [7:0] exp; } item_t;
  item_t      exp_q[$];
  logic [7:0] act_q[$];
  event       got_ev;
  int n_chk = 0, n_fail = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(input string req, input logic [7:0] exp, input logic [7:0] act);
    exp_q.push_back('{req, exp});
    act_q.push_back(act);
    -> got_ev;
    tick(1);
  endtask

  task automatic drain();
    while (act_q.size() > 0) begin
      item_t it;
      logic [7:0] a;
      it = exp_q.pop_front();
      a  = act_q.pop_front();
      n_chk++;
      if (a !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.req, a, it.exp);
      end
    end
  endtask

  initial forever begin
    @(got_ev);
    drain();
  end

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    b = sda_bus; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic scl_glitch();
    m_scl = 1'b1; tick(2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] v, input int glitch_at, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      send_bit(v[i]);
      if (i == glitch_at) scl_glitch();
    end
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~mack);
  endtask

  task automatic write_reg(input string req, input logic [7:0] v);
    logic ack;
    bus_start();
    write_byte(WR_ADDR, -1, ack);
    expect_val({req, " addr ack"}, 8'd1, {7'd0, ack});
    write_byte(v, -1, ack);
    expect_val({req, " data ack"}, 8'd1, {7'd0, ack});
    bus_stop();
  endtask

  task automatic read_reg(input string req, input logic [7:0] exp);
    logic ack;
    logic [7:0] v;
    bus_start();
    write_byte(RD_ADDR, -1, ack);
    expect_val({req, " rd addr ack"}, 8'd1, {7'd0, ack});
    read_byte(1'b0, v);
    expect_val({req, " rd data"}, exp, v);
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(5);
    expect_val("R1 chan_en after reset", 8'h00, {4'h0, chan_en});
    expect_val("R1 sda released after reset", 8'h00, {7'd0, sda_pull});
    read_reg("R1 R3 R7", 8'h00);

    // R6: enables wait for stop
    bus_start();
    write_byte(WR_ADDR, -1, ack);
    expect_val("R3 write addr ack", 8'd1, {7'd0, ack});
    write_byte(8'h06, -1, ack);
    expect_val("R3 write data ack", 8'd1, {7'd0, ack});
    expect_val("R6 chan_en held before stop", 8'h00, {4'h0, chan_en});
    bus_stop();
    expect_val("R6 R5 chan_en after stop", 8'h04, {4'h0, chan_en});

    // R4: last byte wins
    bus_start();
    write_byte(WR_ADDR, -1, ack);
    write_byte(8'h04, -1, ack);
    write_byte(8'h05, -1, ack);
    write_byte(8'h07, -1, ack);
    expect_val("R4 third byte ack", 8'd1, {7'd0, ack});
    bus_stop();
    expect_val("R4 last byte selects ch3", 8'h08, {4'h0, chan_en});

    // R5 disable, R7 flags
    write_reg("R5", 8'h03);
    expect_val("R5 enable bit clear", 8'h00, {4'h0, chan_en});
    irq_n = 4'b1010;
    tick(4);
    read_reg("R7 flags", 8'h53);

    // R11 upper bits ignored
    write_reg("R11", 8'hFF);
    expect_val("R11 chan_en ch3", 8'h08, {4'h0, chan_en});
    read_reg("R11 readback", 8'h57);

    // R8 multi-byte read, release after NACK
    bus_start();
    write_byte(RD_ADDR, -1, ack);
    read_byte(1'b1, v);
    expect_val("R8 first read byte", 8'h57, v);
    read_byte(1'b0, v);
    expect_val("R8 second read byte", 8'h57, v);
    tick(Q);
    expect_val("R8 sda released after nack", 8'h00, {7'd0, sda_pull});
    bus_stop();

    // R2 wrong address
    bus_start();
    write_byte(BAD_WR, -1, ack);
    expect_val("R2 no ack on other address", 8'd0, {7'd0, ack});
    write_byte(8'h04, -1, ack);
    expect_val("R2 no ack on data", 8'd0, {7'd0, ack});
    bus_stop();
    expect_val("R2 chan_en unchanged", 8'h08, {4'h0, chan_en});

    // R10 abort mid-byte by stop
    bus_start();
    write_byte(WR_ADDR, -1, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    expect_val("R10 chan_en unchanged", 8'h08, {4'h0, chan_en});
    read_reg("R10 register unchanged", 8'h57);

    // pending activation and abort on one stop
    bus_start();
    write_byte(WR_ADDR, -1, ack);
    write_byte(8'h06, -1, ack);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    bus_stop();
    expect_val("R6 R10 stop applies first byte", 8'h04, {4'h0, chan_en});
    read_reg("R10 truncated byte dropped", 8'h56);

    // R9 SDA glitch while SCL high is not a start
    m_sda = 1'b0; tick(2);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
    write_byte(WR_ADDR, -1, ack);
    expect_val("R9 no ack without real start", 8'd0, {7'd0, ack});
    bus_stop();

    // R9 SCL glitch during data is not a clock
    bus_start();
    write_byte(WR_ADDR, -1, ack);
    write_byte(8'h04, 4, ack);
    expect_val("R9 ack despite scl glitch", 8'd1, {7'd0, ack});
    bus_stop();
    expect_val("R9 R5 glitch-free data ch0", 8'h01, {4'h0, chan_en});

    tick(10);
    drain();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    drain();
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule